// File: doc/BRIEF.md
# Disk Record Address Sequencer

This block sequences word-by-word sector transfers on a two-drive moving-head disk controller. A single record address register holds a target cylinder, head and sector and is shared by both drives. Each drive also keeps its own position (cylinder and head), which a seek copies from the register. When a transfer starts, the first word strobe of every sector is a sector-start check. The check compares the register with the selected drive's position and decides whether the sector may be transferred. The block then counts words and advances the sector, and the head when the sector wraps, after each full sector.

Data words are not stored here. The block reports the word index, a one-cycle sector-done pulse, a fill flag for write slots with no host data, and one of three error flags: address error, end of cylinder or write protect. A verify operation runs for a loaded sector count. A read-address operation returns two identification words through `addrWord`.

Top module: `recaddr_seq`

## Requirements
- R1: After reset the register cylinder, head and sector, both drive positions, the word index, `busy` and all three error flags are zero.
- R2: While idle, `ldCyl` loads the register cylinder, `ldHdSec` loads the register head and sector, and `seekReq` copies the register cylinder and head into the position of drive `drvSel`. A cylinder of 203 or more places that drive at cylinder 0. All three strobes are ignored while `busy` is high.
- R3: On the first word strobe of a sector, a cylinder or head mismatch between the register and the selected drive, or a register sector of 23 or more, sets `addrErr` and ends the operation. That strobe is not counted.
- R4: When the sector-start check passes but the register head is 20 or more, `eocErr` is set and the operation ends.
- R5: A write (`opMode` = 1) to a drive with `wrProtect` high at sector start sets `protErr` and ends the operation with no transfer. This check has priority over the address checks.
- R6: In read (0), write (1) and verify (2) modes, each accepted word strobe advances `wordIdx`. After the last word of the sector, `wordIdx` returns to 0 and `sectorDone` pulses for exactly one clock.
- R7: After each full sector the register sector increments modulo 23. When it wraps to 0, the head increments in both the register and the selected drive's position.
- R8: During a write, an accepted word strobe with `wrValid` low raises `fillZero` in the same cycle, which marks a zero fill word.
- R9: Verify mode loads the 9-bit `verifyCount` at start and decrements it modulo 512 after each full sector. The operation ends when the count reaches zero.
- R10: In read-address mode (3), the first word strobe puts the drive cylinder in `addrWord[7:0]`. The second strobe puts the drive head in bits 12:8 and the register sector in bits 4:0. After the second word the register sector increments modulo 23 and the operation ends.
- R11: `stopPulse` ends an active operation at any word without advancing the sector. Every operation end produces a one-cycle `opDone` pulse and drops `busy`.
- R12: `startPulse` clears the three error flags and is ignored while busy. At most one error flag is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin an operation in `opMode` on drive `drvSel` |
| stopPulse | input | 1 | End the active operation |
| opMode | input | 2 | 0 read, 1 write, 2 verify, 3 read address |
| drvSel | input | 1 | Drive select for start and seek |
| verifyCount | input | 9 | Sector count for verify |
| wordStrobe | input | 1 | One word slot from the drive |
| wrValid | input | 1 | Host supplied data for this write slot |
| wrProtect | input | 1 | Selected drive is write protected |
| ldCyl | input | 1 | Load register cylinder |
| ldCylVal | input | 8 | Cylinder value |
| ldHdSec | input | 1 | Load register head and sector |
| ldHeadVal | input | 5 | Head value |
| ldSecVal | input | 5 | Sector value |
| seekReq | input | 1 | Copy register into drive position |
| busy | output | 1 | Operation active |
| wordIdx | output | 7 | Word index within the sector |
| sectorDone | output | 1 | One-cycle pulse after a full sector |
| opDone | output | 1 | One-cycle pulse when an operation ends |
| fillZero | output | 1 | Current write slot is zero fill |
| addrErr | output | 1 | Address error |
| eocErr | output | 1 | End of cylinder |
| protErr | output | 1 | Write protect violation |
| addrWord | output | 16 | Read-address result word |
| regCyl | output | 8 | Register cylinder |
| regHead | output | 5 | Register head |
| regSec | output | 5 | Register sector |

## Verification
The bench builds the block with four words per sector and the default geometry of 23 sectors, 20 heads and 203 cylinders. With short sectors, a full track of 23 sectors takes under a hundred strobes. That brings the sector wrap, the head step into drive and register, and the end-of-cylinder stop after head 19 within reach of directed and random runs. Multi-sector verify counts also complete in a few dozen strobes. The default geometry keeps the sector and cylinder limits at their real values, so the sector-23 address error and the out-of-range seek are exercised as built.

// File: rtl/recaddr_pkg.sv
package recaddr_pkg;
  localparam int CYL_W = 8;
  localparam int HD_W  = 5;
  localparam int SC_W  = 5;
  localparam int CNT_W = 9;

  typedef enum logic [1:0] {
    MODE_READ   = 2'd0,
    MODE_WRITE  = 2'd1,
    MODE_VERIFY = 2'd2,
    MODE_RDADDR = 2'd3
  } op_mode_e;

  typedef struct packed {
    logic ldCyl;
    logic ldHdSec;
    logic seek;
    logic startOp;
    logic incIdx;
    logic clrIdx;
    logic advSector;
    logic decCnt;
    logic raFirst;
    logic raSecond;
  } strobes_t;
endpackage

// File: rtl/recaddr_dp.sv
module recaddr_dp
  import recaddr_pkg::*;
#(
  parameter int WORDS = 128,
  parameter int SECS  = 23,
  parameter int HEADS = 20,
  parameter int CYLS  = 203,
  parameter int NDRV  = 2,
  localparam int IDX_W = $clog2(WORDS),
  localparam int DRV_W = (NDRV > 1) ? $clog2(NDRV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobes_t         st,
  input  logic             busyIn,
  input  logic             ldCylRaw,
  input  logic [DRV_W-1:0] drvSel,
  input  logic [CYL_W-1:0] ldCylVal,
  input  logic [HD_W-1:0]  ldHeadVal,
  input  logic [SC_W-1:0]  ldSecVal,
  input  logic [CNT_W-1:0] cntVal,
  output logic             idxZero,
  output logic             idxLast,
  output logic             addrOk,
  output logic             headBad,
  output logic             cntOne,
  output logic [IDX_W-1:0] wordIdx,
  output logic [CYL_W-1:0] regCyl,
  output logic [HD_W-1:0]  regHead,
  output logic [SC_W-1:0]  regSec,
  output logic [15:0]      addrWord
);
  localparam logic [SC_W:0]    SEC_LIM  = (SC_W+1)'(SECS);
  localparam logic [SC_W-1:0]  SEC_LAST = SC_W'(SECS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORDS - 1);

  logic [CYL_W-1:0] posCyl  [NDRV];
  logic [HD_W-1:0]  posHead [NDRV];
  logic [DRV_W-1:0] curDrv;
  logic [CNT_W-1:0] cntReg;
  logic [SC_W:0]    secPlus;
  logic [SC_W-1:0]  secNext;
  logic             secWrap;

  assign secPlus = {1'b0, regSec} + 1'b1;
  assign secNext = (secPlus >= SEC_LIM) ? SC_W'(secPlus - SEC_LIM) : SC_W'(secPlus);
  assign secWrap = (secNext == '0);

  assign idxZero = (wordIdx == '0);
  assign idxLast = (wordIdx == IDX_LAST);
  assign addrOk  = (posCyl[curDrv] == regCyl) && (posHead[curDrv] == regHead)
                   && ({1'b0, regSec} < SEC_LIM);
  assign headBad = (regHead >= HD_W'(HEADS));
  assign cntOne  = (cntReg == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regCyl   <= '0;
      regHead  <= '0;
      regSec   <= '0;
      curDrv   <= '0;
      cntReg   <= '0;
      wordIdx  <= '0;
      addrWord <= '0;
      for (int d = 0; d < NDRV; d++) begin
        posCyl[d]  <= '0;
        posHead[d] <= '0;
      end
    end else begin
      if (st.ldCyl) regCyl <= ldCylVal;
      if (st.ldHdSec) begin
        regHead <= ldHeadVal;
        regSec  <= ldSecVal;
      end
      if (st.startOp) begin
        curDrv <= drvSel;
        cntReg <= cntVal;
      end
      if (st.clrIdx || st.startOp) wordIdx <= '0;
      else if (st.incIdx || st.raFirst) wordIdx <= idxLast ? '0 : wordIdx + 1'b1;
      if (st.advSector) begin
        regSec <= secNext;
        if (secWrap) regHead <= regHead + 1'b1;
      end
      if (st.raSecond) regSec <= secNext;
      if (st.decCnt) cntReg <= cntReg - 1'b1;
      if (st.raFirst) addrWord <= 16'(posCyl[curDrv]);
      if (st.raSecond) addrWord <= {3'b000, posHead[curDrv], 3'b000, regSec};
      for (int d = 0; d < NDRV; d++) begin
        if (st.seek && drvSel == DRV_W'(d)) begin
          posCyl[d]  <= (regCyl >= CYL_W'(CYLS)) ? '0 : regCyl;
          posHead[d] <= regHead;
        end
        if (st.advSector && secWrap && curDrv == DRV_W'(d))
          posHead[d] <= regHead + 1'b1;
      end
    end
  end

  // R2: a cylinder load while busy leaves the register untouched
  a_r2_load_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busyIn && ldCylRaw |=> regCyl == $past(regCyl));

  // R7: the sector wraps to zero exactly after the last sector of the track
  a_r7_sector_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    st.advSector |=> ((regSec == '0) == ($past(regSec) == SEC_LAST)));

  // R7: a sector wrap steps the register head by one
  a_r7_head_step: assert property (@(posedge clk) disable iff (!rst_n)
    st.advSector && regSec == SEC_LAST |=> regHead == $past(regHead) + 1'b1);
endmodule

// File: rtl/recaddr_ctrl.sv
module recaddr_ctrl
  import recaddr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     startPulse,
  input  logic     stopPulse,
  input  logic [1:0] opMode,
  input  logic     wordStrobe,
  input  logic     wrValid,
  input  logic     wrProtect,
  input  logic     ldCyl,
  input  logic     ldHdSec,
  input  logic     seekReq,
  input  logic     idxZero,
  input  logic     idxLast,
  input  logic     addrOk,
  input  logic     headBad,
  input  logic     cntOne,
  output strobes_t st,
  output logic     busy,
  output logic     sectorDone,
  output logic     opDone,
  output logic     fillZero,
  output logic     addrErr,
  output logic     eocErr,
  output logic     protErr
);
  typedef enum logic [1:0] {S_IDLE, S_XFER, S_RDA} state_e;

  state_e   state;
  op_mode_e modeLat;
  logic     endOp, setA, setE, setP, sdNext;

  assign busy = (state != S_IDLE);

  always_comb begin
    st         = '0;
    endOp      = 1'b0;
    setA       = 1'b0;
    setE       = 1'b0;
    setP       = 1'b0;
    sdNext     = 1'b0;
    fillZero   = 1'b0;
    st.ldCyl   = ldCyl && !busy;
    st.ldHdSec = ldHdSec && !busy;
    st.seek    = seekReq && !busy;
    case (state)
      S_IDLE: st.startOp = startPulse;
      S_XFER: begin
        if (stopPulse) endOp = 1'b1;
        else if (wordStrobe) begin
          if (idxZero && modeLat == MODE_WRITE && wrProtect) begin
            setP = 1'b1; endOp = 1'b1;
          end else if (idxZero && !addrOk) begin
            setA = 1'b1; endOp = 1'b1;
          end else if (idxZero && headBad) begin
            setE = 1'b1; endOp = 1'b1;
          end else begin
            st.incIdx = 1'b1;
            fillZero  = (modeLat == MODE_WRITE) && !wrValid;
            if (idxLast) begin
              sdNext       = 1'b1;
              st.advSector = 1'b1;
              if (modeLat == MODE_VERIFY) begin
                st.decCnt = 1'b1;
                if (cntOne) endOp = 1'b1;
              end
            end
          end
        end
      end
      S_RDA: begin
        if (stopPulse) endOp = 1'b1;
        else if (wordStrobe) begin
          if (idxZero) st.raFirst = 1'b1;
          else begin
            st.raSecond = 1'b1;
            endOp       = 1'b1;
          end
        end
      end
      default: ;
    endcase
    if (endOp) st.clrIdx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      modeLat    <= MODE_READ;
      sectorDone <= 1'b0;
      opDone     <= 1'b0;
      addrErr    <= 1'b0;
      eocErr     <= 1'b0;
      protErr    <= 1'b0;
    end else begin
      sectorDone <= sdNext;
      opDone     <= endOp;
      if (st.startOp) begin
        modeLat <= op_mode_e'(opMode);
        state   <= (op_mode_e'(opMode) == MODE_RDADDR) ? S_RDA : S_XFER;
        addrErr <= 1'b0;
        eocErr  <= 1'b0;
        protErr <= 1'b0;
      end else if (endOp) begin
        state <= S_IDLE;
      end
      if (setA) addrErr <= 1'b1;
      if (setE) eocErr  <= 1'b1;
      if (setP) protErr <= 1'b1;
    end
  end

  // R12: never more than one error flag
  a_r12_one_err: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addrErr, eocErr, protErr}));

  // R11: the end-of-operation pulse lasts a single clock
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    opDone |=> !opDone);

  // R3: an error flag is only ever seen with the sequencer stopped
  a_r3_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (addrErr || eocErr || protErr) |-> !busy);
endmodule

// File: rtl/recaddr_seq.sv
module recaddr_seq
  import recaddr_pkg::*;
#(
  parameter int WORDS = 128,
  parameter int SECS  = 23,
  parameter int HEADS = 20,
  parameter int CYLS  = 203,
  parameter int NDRV  = 2,
  localparam int IDX_W = $clog2(WORDS),
  localparam int DRV_W = (NDRV > 1) ? $clog2(NDRV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startPulse,
  input  logic             stopPulse,
  input  logic [1:0]       opMode,
  input  logic [DRV_W-1:0] drvSel,
  input  logic [CNT_W-1:0] verifyCount,
  input  logic             wordStrobe,
  input  logic             wrValid,
  input  logic             wrProtect,
  input  logic             ldCyl,
  input  logic [CYL_W-1:0] ldCylVal,
  input  logic             ldHdSec,
  input  logic [HD_W-1:0]  ldHeadVal,
  input  logic [SC_W-1:0]  ldSecVal,
  input  logic             seekReq,
  output logic             busy,
  output logic [IDX_W-1:0] wordIdx,
  output logic             sectorDone,
  output logic             opDone,
  output logic             fillZero,
  output logic             addrErr,
  output logic             eocErr,
  output logic             protErr,
  output logic [15:0]      addrWord,
  output logic [CYL_W-1:0] regCyl,
  output logic [HD_W-1:0]  regHead,
  output logic [SC_W-1:0]  regSec
);
  strobes_t st;
  logic idxZero, idxLast, addrOk, headBad, cntOne;

  recaddr_ctrl u_ctrl (
    .clk, .rst_n, .startPulse, .stopPulse, .opMode, .wordStrobe, .wrValid,
    .wrProtect, .ldCyl, .ldHdSec, .seekReq, .idxZero, .idxLast, .addrOk,
    .headBad, .cntOne, .st, .busy, .sectorDone, .opDone, .fillZero,
    .addrErr, .eocErr, .protErr
  );

  recaddr_dp #(
    .WORDS(WORDS), .SECS(SECS), .HEADS(HEADS), .CYLS(CYLS), .NDRV(NDRV)
  ) u_dp (
    .clk, .rst_n, .st, .busyIn(busy), .ldCylRaw(ldCyl), .drvSel, .ldCylVal,
    .ldHeadVal, .ldSecVal, .cntVal(verifyCount), .idxZero, .idxLast, .addrOk,
    .headBad, .cntOne, .wordIdx, .regCyl, .regHead, .regSec, .addrWord
  );

  // R6: a sector-done pulse always coincides with the index back at zero
  a_r6_idx_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    sectorDone |-> wordIdx == '0);
endmodule

// File: tb/sim_recaddr_seq.sv
`timescale 1ns/1ps
module sim_recaddr_seq;
  localparam int WORDS = 4;
  localparam int SECS  = 23;
  localparam int HEADS = 20;
  localparam int CYLS  = 203;

  logic clk = 0, rst_n = 0;
  logic startPulse = 0, stopPulse = 0, wordStrobe = 0, wrValid = 0, wrProtect = 0;
  logic [1:0] opMode = 0;
  logic drvSel = 0;
  logic [8:0] verifyCount = 0;
  logic ldCyl = 0, ldHdSec = 0, seekReq = 0;
  logic [7:0] ldCylVal = 0;
  logic [4:0] ldHeadVal = 0, ldSecVal = 0;
  logic busy, sectorDone, opDone, fillZero, addrErr, eocErr, protErr;
  logic [1:0] wordIdx;
  logic [15:0] addrWord;
  logic [7:0] regCyl;
  logic [4:0] regHead, regSec;

  always #5 clk = ~clk;

  recaddr_seq #(.WORDS(WORDS)) u0 (
    .clk, .rst_n, .startPulse, .stopPulse, .opMode, .drvSel, .verifyCount,
    .wordStrobe, .wrValid, .wrProtect, .ldCyl, .ldCylVal, .ldHdSec, .ldHeadVal,
    .ldSecVal, .seekReq, .busy, .wordIdx, .sectorDone, .opDone, .fillZero,
    .addrErr, .eocErr, .protErr, .addrWord, .regCyl, .regHead, .regSec
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  int mCyl, mHead, mSec, mIdx, mCnt, mMode, mDrv;
  int pCyl[2], pHead[2];
  bit mBusy;
  int eA, eE, eP;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nextSec(int s);
    return (s + 1 >= SECS) ? s + 1 - SECS : s + 1;
  endfunction

  task automatic checkRegs(string req);
    chk({req, " regCyl"}, regCyl, mCyl);
    chk({req, " regHead"}, regHead, mHead);
    chk({req, " regSec"}, regSec, mSec);
  endtask

  task automatic loadCyl(int v);
    @(negedge clk); ldCyl = 1; ldCylVal = v[7:0];
    @(negedge clk); ldCyl = 0;
    if (!mBusy) mCyl = v;
  endtask

  task automatic loadHS(int h, int s);
    @(negedge clk); ldHdSec = 1; ldHeadVal = h[4:0]; ldSecVal = s[4:0];
    @(negedge clk); ldHdSec = 0;
    if (!mBusy) begin mHead = h; mSec = s; end
  endtask

  task automatic seek(int d);
    @(negedge clk); seekReq = 1; drvSel = d[0];
    @(negedge clk); seekReq = 0;
    if (!mBusy) begin pCyl[d] = (mCyl >= CYLS) ? 0 : mCyl; pHead[d] = mHead; end
  endtask

  task automatic startOp(int mode, int d, int cnt, bit wp);
    @(negedge clk); startPulse = 1; opMode = mode[1:0]; drvSel = d[0];
    verifyCount = cnt[8:0]; wrProtect = wp;
    @(negedge clk); startPulse = 0;
    mBusy = 1; mMode = mode; mDrv = d; mIdx = 0; mCnt = cnt; eA = 0; eE = 0; eP = 0;
    chk("R12 busy after start", busy, 1);
    chk("R12 errors cleared", {addrErr, eocErr, protErr}, 0);
  endtask

  task automatic strobe(bit valid);
    int expFill = 0, expSd = 0, endNow = 0, expAddr = -1;
    if (mMode == 3) begin
      if (mIdx == 0) begin expAddr = pCyl[mDrv]; mIdx = 1; end
      else begin
        expAddr = pHead[mDrv] * 256 + mSec; mSec = nextSec(mSec); mIdx = 0; endNow = 1;
      end
    end else begin
      bit ok = 1;
      if (mIdx == 0) begin
        if (mMode == 1 && wrProtect) begin eP = 1; ok = 0; end
        else if (mCyl != pCyl[mDrv] || mHead != pHead[mDrv] || mSec >= SECS) begin eA = 1; ok = 0; end
        else if (mHead >= HEADS) begin eE = 1; ok = 0; end
      end
      if (!ok) endNow = 1;
      else begin
        if (mMode == 1 && !valid) expFill = 1;
        mIdx++;
        if (mIdx == WORDS) begin
          mIdx = 0; expSd = 1; mSec = nextSec(mSec);
          if (mSec == 0) begin mHead = (mHead + 1) % 32; pHead[mDrv] = mHead; end
          if (mMode == 2) begin mCnt = (mCnt - 1) & 511; if (mCnt == 0) endNow = 1; end
        end
      end
    end
    @(negedge clk); wordStrobe = 1; wrValid = valid;
    #1 chk("R8 fillZero", fillZero, expFill);
    @(negedge clk); wordStrobe = 0;
    if (endNow) mBusy = 0;
    chk("R6 wordIdx", wordIdx, mIdx);
    chk("R6 sectorDone", sectorDone, expSd);
    chk("R11 opDone", opDone, endNow);
    chk("R11 busy", busy, mBusy);
    chk("R3 addrErr", addrErr, eA);
    chk("R4 eocErr", eocErr, eE);
    chk("R5 protErr", protErr, eP);
    if (expAddr >= 0) chk("R10 addrWord", addrWord, expAddr);
    checkRegs("R7");
  endtask

  task automatic stop();
    if (mBusy) begin
      @(negedge clk); stopPulse = 1;
      @(negedge clk); stopPulse = 0;
      mBusy = 0; mIdx = 0;
      chk("R11 stop opDone", opDone, 1);
      chk("R11 stop busy", busy, 0);
      chk("R11 stop wordIdx", wordIdx, 0);
      checkRegs("R11 stop no advance");
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1729));
    mCyl = 0; mHead = 0; mSec = 0; mBusy = 0;
    pCyl[0] = 0; pCyl[1] = 0; pHead[0] = 0; pHead[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    checkRegs("R1");
    chk("R1 busy", busy, 0);
    chk("R1 wordIdx", wordIdx, 0);
    chk("R1 errors", {addrErr, eocErr, protErr}, 0);
    startOp(3, 0, 0, 0); strobe(0); strobe(0);  // R1 drive 0 position is zero

    // R2/R10 seek then read address on drive 1
    loadCyl(5); loadHS(3, 7); seek(1);
    startOp(3, 1, 0, 0); strobe(0); strobe(0);
    chk("R10 sector stepped", regSec, 8);

    // R2 out-of-range seek lands at cylinder 0
    loadCyl(210); seek(0);
    startOp(3, 0, 0, 0); strobe(0); strobe(0);

    // R2 loads ignored while busy, R12 start ignored while busy
    loadCyl(5); loadHS(3, 8);
    startOp(0, 1, 0, 0);
    loadCyl(9); loadHS(1, 1); seek(1);
    chk("R2 cyl load ignored busy", regCyl, 5);
    @(negedge clk); startPulse = 1; opMode = 2'd3;
    @(negedge clk); startPulse = 0;
    strobe(1);  // still a read transfer
    stop();

    // R7/R4 head wrap then end of cylinder
    loadCyl(2); loadHS(19, 22); seek(0);
    startOp(0, 0, 0, 0);
    for (int i = 0; i < WORDS; i++) strobe(1);
    chk("R7 head wrapped", regHead, 20);
    chk("R7 sector wrapped", regSec, 0);
    strobe(1);
    chk("R4 eoc directed", eocErr, 1);

    // R3 head mismatch and bad sector
    loadHS(4, 0);
    startOp(0, 0, 0, 0); strobe(1);
    chk("R3 head mismatch", addrErr, 1);
    loadHS(20, 23);
    startOp(0, 0, 0, 0); strobe(1);
    chk("R3 sector 23", addrErr, 1);

    // R5 protect has priority over a mismatch
    startOp(1, 1, 0, 1); strobe(1);
    chk("R5 protect priority", protErr, 1);

    // R8 write with fill slots
    loadCyl(7); loadHS(0, 0); seek(1);
    startOp(1, 1, 0, 0);
    for (int i = 0; i < 6; i++) strobe(i[0]);
    stop();

    // R9 verify of two sectors
    startOp(2, 1, 2, 0);
    for (int i = 0; i < 2 * WORDS; i++) strobe(1);
    chk("R9 verify ended", busy, 0);

    // random mix
    for (int it = 0; it < 80; it++) begin
      int r = $urandom_range(0, 9);
      if (r < 4) loadCyl(($urandom_range(0, 7) == 0) ? 205 : $urandom_range(0, 3));
      r = $urandom_range(0, 9);
      if (r < 5) loadHS($urandom_range(0, 21), $urandom_range(0, 24));
      if ($urandom_range(0, 2) == 0) seek($urandom_range(0, 1));
      begin
        int mode = $urandom_range(0, 3);
        int d = $urandom_range(0, 1);
        int n = (mode == 3) ? $urandom_range(1, 2) : $urandom_range(1, 3 * WORDS);
        startOp(mode, d, $urandom_range(1, 2), $urandom_range(0, 3) == 0);
        for (int k = 0; k < n && mBusy; k++) strobe($urandom_range(0, 1));
        stop();
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule